// File: doc/BRIEF.md
# Dual-Context Speculation Control Register

This block holds a speculation control vector in two copies: one that belongs to the host and one that belongs to the guest currently scheduled on the core. Register writes land in the copy of the current mode, and reads return that same copy. A guest that writes a value always reads that value back. Downstream speculation logic sees one effective vector. In host mode that vector is the host copy alone. In guest mode it is the bitwise OR of both copies, so the host can impose a minimum set of control bits that the guest cannot clear.

Mode changes are driven by two event pulses: guest entry and guest exit. On entry, the block captures a save-area base pointer. It fetches the guest copy from the 32-bit word at byte offset 0x2E0 above that base, and guest mode begins only once the fetched word has arrived. On exit, the block writes the guest copy back to the same word. Host mode resumes only after the memory side acknowledges the store. While either transfer is in flight, register writes are held back through a ready/valid handshake. A fixed capability word advertises the feature in bit 20. No enable bit exists: the feature is always active.

Top module: `specctl_ctx`

## Requirements
- R1: After reset both copies are zero, the block is in host mode (`guest_active` = 0), `ctrl_eff` and `rd_value` are zero, `wr_ready` is 1 and no memory request is raised.
- R2: In host mode an accepted write replaces the host copy only; `rd_value` and `ctrl_eff` show the new value from the next cycle.
- R3: In guest mode an accepted write replaces the guest copy only; the host copy keeps its value, which is visible in `ctrl_eff` and `rd_value` once host mode resumes.
- R4: A guest-entry pulse in host mode raises a read request (`mem_req_write` = 0) at `save_base` + 0x2E0 (base sampled with the pulse). `guest_active` rises in the cycle after the read response and never earlier, and the returned word becomes the guest copy.
- R5: A guest-exit pulse in guest mode raises a write request (`mem_req_write` = 1) at the captured base + 0x2E0 carrying the guest copy. Host mode resumes in the cycle after the write acknowledgement. Outside guest mode, `ctrl_eff` equals the host copy.
- R6: In guest mode `ctrl_eff` equals guest copy OR host copy, so host bits stay set even when the guest writes zero.
- R7: While a load or store transition is in progress `wr_ready` is 0 and no copy changes; a write held across the transition is applied to the copy of the mode that follows it.
- R8: `cap_word` has bit 20 set and every other bit clear.
- R9: An entry pulse outside host mode and an exit pulse outside guest mode are ignored: no memory request and no mode change.
- R10: A memory request stays raised with unchanged address, direction and data until `mem_req_ready` accepts it, and drops in the cycle after acceptance.
- R11: In guest mode `rd_value` returns the guest copy, including a value just loaded from the save area and never written by the guest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Guest-entry event pulse |
| exit_req | input | 1 | Guest-exit event pulse |
| save_base | input | ADDR_W | Save-area base byte address, sampled with `entry_req` |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Register write accepted this cycle when high with `wr_valid` |
| wr_data | input | CTRL_W | Register write value |
| rd_value | output | CTRL_W | Copy of the current mode |
| ctrl_eff | output | CTRL_W | Effective speculation control vector |
| guest_active | output | 1 | High in guest mode |
| cap_word | output | CAP_W | Capability word with the feature bit set |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | ADDR_W | Byte address of the save-area word |
| mem_req_wdata | output | CTRL_W | Store data |
| mem_rsp_valid | input | 1 | Load data return or store acknowledgement |
| mem_rsp_data | input | CTRL_W | Load data |

## Verification
A copy steered to the wrong side shows up within one cycle: `rd_value` in the current mode and `ctrl_eff` both change. The damage to the other copy shows up later, either when the mode flips back or in the data of the next save-area store. A sequencer that leaves a transition early raises `guest_active` or drops to host mode before the memory response, in the same cycle the response would have arrived. A wrong stall shows as `wr_ready` high while a request is outstanding. A lost floor shows as a host bit missing from `ctrl_eff` right after a guest write of zero.

// File: rtl/specctl_pkg.sv
package specctl_pkg;

    typedef enum logic [1:0] {
        MODE_HOST       = 2'd0,
        MODE_ENTRY_LOAD = 2'd1,
        MODE_GUEST      = 2'd2,
        MODE_EXIT_STORE = 2'd3
    } mode_e;

    localparam int unsigned SLOT_OFFSET_DEF = 32'h2E0;
    localparam int unsigned CAP_BIT_DEF     = 20;

endpackage

// File: rtl/specctl_seq.sv
// Mode sequencer: owns the four-state mode, the captured save-area base
// and the single-word memory request port.
module specctl_seq
    import specctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CTRL_W      = 32,
    parameter int unsigned SLOT_OFFSET = SLOT_OFFSET_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_req,
    input  logic              exit_req,
    input  logic [ADDR_W-1:0] save_base,
    input  logic [CTRL_W-1:0] guest_copy,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    output mode_e             mode,
    output logic              load_en,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [CTRL_W-1:0] mem_req_wdata
);

    localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(SLOT_OFFSET);

    typedef struct packed {
        mode_e             mode;
        logic              sent;
        logic [ADDR_W-1:0] base;
    } seq_t;

    seq_t seq_d, seq_q;
    logic in_xfer;

    always_comb begin
        seq_d   = seq_q;
        load_en = 1'b0;
        in_xfer = (seq_q.mode == MODE_ENTRY_LOAD) || (seq_q.mode == MODE_EXIT_STORE);

        if (in_xfer && !seq_q.sent && mem_req_ready) begin
            seq_d.sent = 1'b1;
        end

        unique case (seq_q.mode)
            MODE_HOST: begin
                if (entry_req) begin
                    seq_d.mode = MODE_ENTRY_LOAD;
                    seq_d.sent = 1'b0;
                    seq_d.base = save_base;
                end
            end
            MODE_ENTRY_LOAD: begin
                if (seq_q.sent && mem_rsp_valid) begin
                    load_en    = 1'b1;
                    seq_d.mode = MODE_GUEST;
                    seq_d.sent = 1'b0;
                end
            end
            MODE_GUEST: begin
                if (exit_req) begin
                    seq_d.mode = MODE_EXIT_STORE;
                    seq_d.sent = 1'b0;
                end
            end
            MODE_EXIT_STORE: begin
                if (seq_q.sent && mem_rsp_valid) begin
                    seq_d.mode = MODE_HOST;
                    seq_d.sent = 1'b0;
                end
            end
            default: seq_d.mode = MODE_HOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{mode: MODE_HOST, sent: 1'b0, base: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode          = seq_q.mode;
    assign mem_req_valid = in_xfer && !seq_q.sent;
    assign mem_req_write = (seq_q.mode == MODE_EXIT_STORE);
    assign mem_req_addr  = seq_q.base + OFFSET;
    assign mem_req_wdata = guest_copy;

endmodule

// File: rtl/specctl_bank.sv
// Two-copy register bank with mode-steered writes and a load path into
// the guest copy.
module specctl_bank
    import specctl_pkg::*;
#(
    parameter int unsigned CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              wr_fire,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [CTRL_W-1:0] load_data,
    output logic [CTRL_W-1:0] host_copy,
    output logic [CTRL_W-1:0] guest_copy
);

    typedef struct packed {
        logic [CTRL_W-1:0] host;
        logic [CTRL_W-1:0] guest;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_fire) begin
            if (mode == MODE_GUEST) begin
                bank_d.guest = wr_data;
            end else if (mode == MODE_HOST) begin
                bank_d.host = wr_data;
            end
        end
        if (load_en) begin
            bank_d.guest = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign host_copy  = bank_q.host;
    assign guest_copy = bank_q.guest;

endmodule

// File: rtl/specctl_merge.sv
// Output stage: effective vector, read mux, write stall and capability word.
module specctl_merge
    import specctl_pkg::*;
#(
    parameter int unsigned CTRL_W  = 32,
    parameter int unsigned CAP_W   = 32,
    parameter int unsigned CAP_BIT = CAP_BIT_DEF
) (
    input  mode_e             mode,
    input  logic [CTRL_W-1:0] host_copy,
    input  logic [CTRL_W-1:0] guest_copy,
    output logic [CTRL_W-1:0] ctrl_eff,
    output logic [CTRL_W-1:0] rd_value,
    output logic              wr_ready,
    output logic              guest_active,
    output logic [CAP_W-1:0]  cap_word
);

    assign guest_active = (mode == MODE_GUEST);
    assign wr_ready     = (mode == MODE_GUEST) || (mode == MODE_HOST);
    assign rd_value     = guest_active ? guest_copy : host_copy;

    for (genvar b = 0; b < CTRL_W; b++) begin : g_eff
        assign ctrl_eff[b] = host_copy[b] | (guest_active & guest_copy[b]);
    end

    for (genvar c = 0; c < CAP_W; c++) begin : g_cap
        assign cap_word[c] = (c == CAP_BIT);
    end

endmodule

// File: rtl/specctl_ctx.sv
module specctl_ctx
    import specctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CTRL_W      = 32,
    parameter int unsigned CAP_W       = 32,
    parameter int unsigned CAP_BIT     = CAP_BIT_DEF,
    parameter int unsigned SLOT_OFFSET = SLOT_OFFSET_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_req,
    input  logic              exit_req,
    input  logic [ADDR_W-1:0] save_base,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_value,
    output logic [CTRL_W-1:0] ctrl_eff,
    output logic              guest_active,
    output logic [CAP_W-1:0]  cap_word,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [CTRL_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [CTRL_W-1:0] mem_rsp_data
);

    mode_e             mode;
    logic              load_en;
    logic [CTRL_W-1:0] host_copy;
    logic [CTRL_W-1:0] guest_copy;
    logic              wr_fire;

    assign wr_fire = wr_valid && wr_ready;

    specctl_seq #(
        .ADDR_W     (ADDR_W),
        .CTRL_W     (CTRL_W),
        .SLOT_OFFSET(SLOT_OFFSET)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_req    (entry_req),
        .exit_req     (exit_req),
        .save_base    (save_base),
        .guest_copy   (guest_copy),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mode         (mode),
        .load_en      (load_en),
        .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata)
    );

    specctl_bank #(
        .CTRL_W(CTRL_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .wr_fire   (wr_fire),
        .wr_data   (wr_data),
        .load_en   (load_en),
        .load_data (mem_rsp_data),
        .host_copy (host_copy),
        .guest_copy(guest_copy)
    );

    specctl_merge #(
        .CTRL_W (CTRL_W),
        .CAP_W  (CAP_W),
        .CAP_BIT(CAP_BIT)
    ) u_merge (
        .mode        (mode),
        .host_copy   (host_copy),
        .guest_copy  (guest_copy),
        .ctrl_eff    (ctrl_eff),
        .rd_value    (rd_value),
        .wr_ready    (wr_ready),
        .guest_active(guest_active),
        .cap_word    (cap_word)
    );

endmodule

// File: rtl/specctl_ctx_chk.sv
module specctl_ctx_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CTRL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] ctrl_eff,
    input logic              guest_active,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [CTRL_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic [CTRL_W-1:0] host_copy,
    input logic [CTRL_W-1:0] guest_copy
);

    assert_host_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !guest_active) |=> (host_copy == $past(wr_data)));

    assert_guest_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && guest_active) |=>
            ($stable(host_copy) && (guest_copy == $past(wr_data))));

    assert_entry_after_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guest_active) |-> $past(mem_rsp_valid));

    assert_host_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !guest_active |-> (ctrl_eff == host_copy));

    assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        guest_active |-> (((ctrl_eff & host_copy) == host_copy) &&
                          ((ctrl_eff & guest_copy) == guest_copy)));

    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !wr_ready);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
             $stable(mem_req_wdata)));

    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

bind specctl_ctx specctl_ctx_chk #(
    .ADDR_W(ADDR_W),
    .CTRL_W(CTRL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .ctrl_eff     (ctrl_eff),
    .guest_active (guest_active),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .host_copy    (host_copy),
    .guest_copy   (guest_copy)
);

// File: tb/specctl_ctx_tb.sv
module specctl_ctx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_req = 1'b0;
    logic        exit_req = 1'b0;
    logic [31:0] save_base = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_value;
    logic [31:0] ctrl_eff;
    logic        guest_active;
    logic [31:0] cap_word;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    specctl_ctx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_req    (entry_req),
        .exit_req     (exit_req),
        .save_base    (save_base),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_data      (wr_data),
        .rd_value     (rd_value),
        .ctrl_eff     (ctrl_eff),
        .guest_active (guest_active),
        .cap_word     (cap_word),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] v);
        wr_valid = 1'b1; wr_data = v;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic do_entry(input logic [31:0] base, input logic [31:0] word,
                            input int delay, input logic host_floor_ok,
                            input logic [31:0] host_val);
        entry_req = 1'b1; save_base = base;
        step();
        entry_req = 1'b0; save_base = 32'hDEAD_0000;
        check(32'(mem_req_valid), 1, "R4 load request raised");
        check(32'(mem_req_write), 0, "R4 request is a load");
        check(mem_req_addr, base + 32'h2E0, "R4 load address");
        check(32'(wr_ready), 0, "R7 writes stalled during load");
        if (host_floor_ok) check(ctrl_eff, host_val, "R5 host only during load");
        for (int i = 0; i < delay; i++) begin
            step();
            check(32'(mem_req_valid), 1, "R10 load request held");
            check(mem_req_addr, base + 32'h2E0, "R10 load address stable");
        end
        mem_req_ready = 1'b1;
        step();
        mem_req_ready = 1'b0;
        check(32'(mem_req_valid), 0, "R10 request dropped after accept");
        check(32'(guest_active), 0, "R4 no guest mode before response");
        step();
        check(32'(guest_active), 0, "R4 still waiting for response");
        mem_rsp_valid = 1'b1; mem_rsp_data = word;
        step();
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        check(32'(guest_active), 1, "R4 guest mode after response");
    endtask

    task automatic do_exit(input logic [31:0] base, input logic [31:0] exp_data,
                           input int delay, input logic [31:0] host_val);
        exit_req = 1'b1;
        step();
        exit_req = 1'b0;
        check(32'(guest_active), 0, "R5 guest mode left");
        check(32'(mem_req_valid), 1, "R5 store request raised");
        check(32'(mem_req_write), 1, "R5 request is a store");
        check(mem_req_addr, base + 32'h2E0, "R5 store address");
        check(mem_req_wdata, exp_data, "R5 store data is guest copy");
        check(ctrl_eff, host_val, "R5 host only during store");
        check(32'(wr_ready), 0, "R7 writes stalled during store");
        for (int i = 0; i < delay; i++) begin
            step();
            check(mem_req_wdata, exp_data, "R10 store data stable");
        end
        mem_req_ready = 1'b1;
        step();
        mem_req_ready = 1'b0;
        check(32'(wr_ready), 0, "R5 host mode waits for ack");
        mem_rsp_valid = 1'b1;
        step();
        mem_rsp_valid = 1'b0;
        check(32'(wr_ready), 1, "R5 host mode after ack");
        check(rd_value, host_val, "R3 host copy untouched by guest");
        check(ctrl_eff, host_val, "R5 effective is host after exit");
    endtask

    task automatic t_reset();
        check(ctrl_eff, 0, "R1 ctrl_eff reset");
        check(rd_value, 0, "R1 rd_value reset");
        check(32'(guest_active), 0, "R1 host mode at reset");
        check(32'(wr_ready), 1, "R1 ready at reset");
        check(32'(mem_req_valid), 0, "R1 no request at reset");
        check(cap_word, 32'h0010_0000, "R8 capability bit 20");
    endtask

    task automatic t_host_write();
        host_write(32'h0000_0005);
        check(rd_value, 32'h5, "R2 host write readback");
        check(ctrl_eff, 32'h5, "R2 host write effective");
    endtask

    task automatic t_ignored_pulses_host();
        exit_req = 1'b1;
        step();
        exit_req = 1'b0;
        check(32'(mem_req_valid), 0, "R9 exit in host: no request");
        check(32'(wr_ready), 1, "R9 exit in host: mode kept");
        check(rd_value, 32'h5, "R9 exit in host: host copy kept");
    endtask

    task automatic t_guest_session();
        do_entry(32'h0000_1000, 32'h0000_00A0, 2, 1'b1, 32'h5);
        check(rd_value, 32'hA0, "R11 loaded guest value reads back");
        check(ctrl_eff, 32'hA5, "R6 OR of guest and host");
        wr_valid = 1'b1; wr_data = 32'h2;
        step();
        wr_valid = 1'b0;
        check(rd_value, 32'h2, "R3 guest write readback");
        check(ctrl_eff, 32'h7, "R6 OR after guest write");
        wr_valid = 1'b1; wr_data = 32'h0;
        step();
        wr_valid = 1'b0;
        check(rd_value, 32'h0, "R11 guest zero reads back");
        check(ctrl_eff, 32'h5, "R6 host floor survives guest zero");
        entry_req = 1'b1; save_base = 32'h0000_8000;
        step();
        entry_req = 1'b0;
        check(32'(mem_req_valid), 0, "R9 entry in guest: no request");
        check(32'(guest_active), 1, "R9 entry in guest: mode kept");
        wr_valid = 1'b1; wr_data = 32'h30;
        step();
        wr_valid = 1'b0;
        do_exit(32'h0000_1000, 32'h30, 1, 32'h5);
    endtask

    task automatic t_stalled_write();
        entry_req = 1'b1; save_base = 32'h0000_2000;
        step();
        entry_req = 1'b0;
        wr_valid = 1'b1; wr_data = 32'h77;
        check(32'(wr_ready), 0, "R7 write stalled at load start");
        mem_req_ready = 1'b1;
        step();
        mem_req_ready = 1'b0;
        check(rd_value, 32'h5, "R7 host copy unchanged while stalled");
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h11;
        step();
        mem_rsp_valid = 1'b0;
        check(32'(guest_active), 1, "R4 guest mode after stalled load");
        check(rd_value, 32'h11, "R7 stalled write not applied early");
        step();
        wr_valid = 1'b0;
        check(rd_value, 32'h77, "R7 held write lands in guest copy");
        check(ctrl_eff, 32'h77, "R6 OR with held write");
        do_exit(32'h0000_2000, 32'h77, 0, 32'h5);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_host_write();
        t_ignored_pulses_host();
        t_guest_session();
        t_stalled_write();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule